// File: doc/BRIEF.md
# Packet Fragment Capture Mailbox

This block sits at the end of a streaming ingress path and keeps a single packet fragment so that a host processor can read it at its own pace. Bytes arrive one per cycle with a valid/ready handshake. Each byte comes with start-of-packet, end-of-packet, channel identifier and three error indications. A separate marker shows the final byte of the fragment. The block stores up to 256 data bytes, together with a header. The header holds the channel identifier, a flag byte and the byte count.

When the final byte is accepted, ownership passes to the host. A data-available flag is raised and a one-cycle capture event is sent toward an interrupt controller. The write side then stalls until the host has read what it needs and clears the flag through a control register.

The host port is a plain register port with 8-bit words. Reads return data one cycle after they are issued. Word 0 is the identifier, word 1 the flags, word 2 the length and words 3 to 258 the data bytes. The control register sits on its own at the top address, 511.

Top module: `frag_capture_mbox`

## Requirements
- R1: After a synchronous active-low reset, data_avail is 0, cap_event is 0 and in_ready is 1.
- R2: Data byte i of the stored fragment (i from 0 to 255) reads back at host address 3+i. host_rdata carries the value in the cycle after the host_rd cycle.
- R3: When a byte with in_last set is accepted, data_avail goes to 1 on the next clock edge. cap_event is 1 for exactly that one cycle.
- R4: Host address 2 returns the number of stored bytes minus one, so a 5-byte fragment reads 4 and a 256-byte fragment reads 255.
- R5: Host address 1 returns the flag byte. Bit 0 is in_sop of the first byte and bit 1 is in_eop of the final byte. Bit 2 is address parity error, bit 3 is data parity error and bit 4 is packet error; each of these three is the OR over all bytes of the fragment. Bits 7 to 5 are 0.
- R6: Host address 0 returns in_lid of the first byte of the fragment, zero-extended to 8 bits.
- R7: While data_avail is 1, in_ready is 0. Bytes offered then are neither stored nor counted, and they raise no event.
- R8: If a fragment carries more than 256 bytes, only the first 256 are stored and the length word reads 255. Packet error (flag bit 4) is set, and completion still waits for in_last.
- R9: A read of a data address at or beyond the stored length returns 0. So does a read of any address from 259 to 510.
- R10: Reading address 511 returns data_avail in bit 0. Writing 511 with bit 0 at 0 clears data_avail and raises in_ready again. Writing 511 with bit 0 at 1 changes nothing.
- R11: A clear written while data_avail is already 0 leaves it at 0 and produces no cap_event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Ingress byte valid |
| in_ready | output | 1 | Mailbox can accept a byte |
| in_data | input | 8 | Ingress data byte |
| in_last | input | 1 | Final byte of the fragment |
| in_sop | input | 1 | Start of packet |
| in_eop | input | 1 | End of packet |
| in_lid | input | LID_W | Logical channel identifier |
| in_aperr | input | 1 | Address parity error |
| in_dperr | input | 1 | Data parity error |
| in_pkterr | input | 1 | Packet error |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HAW | Host word address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after host_rd |
| data_avail | output | 1 | Fragment held for the host |
| cap_event | output | 1 | One-cycle capture event |

## Verification
Four kinds of fragment are sent. A 5-byte fragment with the first and last packet marks and a data parity error on one byte shows whether per-byte errors are merged and whether header bits come from the correct byte. An exact 256-byte fragment tests the top edge of the length encoding and the top data address. A 260-byte fragment with a single address error tests truncation: an address wrap would show up as an overwritten byte 0. A 3-byte fragment that follows the full one leaves stale bytes past its end, and these must read as zero. Bytes offered while the host owns the buffer, and control writes of both polarities in both ownership states, test the handover.

// File: rtl/frag_cap_pkg.sv
// Shared definitions for the fragment capture mailbox.
// Assumes the data word is 8 bits and that a fragment holds at most 256 bytes,
// so the length word (count minus one) fits in one byte.
package frag_cap_pkg;
    localparam int FLAG_SOP    = 0;
    localparam int FLAG_EOP    = 1;
    localparam int FLAG_APERR  = 2;
    localparam int FLAG_DPERR  = 3;
    localparam int FLAG_PKTERR = 4;
    localparam int HDR_WORDS   = 3;

    typedef struct packed {
        logic [7:0] lid;
        logic [7:0] flags;
        logic [7:0] len_m1;
    } frag_hdr_t;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_MEM  = 2'd1,
        SEL_REG  = 2'd2
    } rd_sel_t;
endpackage

// File: rtl/frag_cap_writer.sv
// Write side of the mailbox. It counts accepted bytes, sends them to storage
// and gathers the header (first-byte identifier and SOP, final-byte EOP,
// errors ORed). It commits the header when the final byte is accepted.
// Bytes past DEPTH are dropped and mark a packet error.
// Assumes in_ready comes from the host side and is low while the host owns the buffer.
module frag_cap_writer
    import frag_cap_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LID_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_ready,
    input  logic [7:0]                in_data,
    input  logic                      in_last,
    input  logic                      in_sop,
    input  logic                      in_eop,
    input  logic [LID_W-1:0]          in_lid,
    input  logic                      in_aperr,
    input  logic                      in_dperr,
    input  logic                      in_pkterr,
    output logic                      mem_we,
    output logic [$clog2(DEPTH)-1:0]  mem_waddr,
    output logic [7:0]                mem_wdata,
    output logic                      commit,
    output frag_hdr_t                 hdr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    new_cnt;
    logic [LID_W-1:0] w_lid, cur_lid;
    logic             w_sop, w_ap, w_dp, w_pk;
    logic             cur_sop, cur_ap, cur_dp, cur_pk;
    logic             acc, first, full;

    // Handshake, fill state and the header values that include the current byte.
    always_comb begin
        acc       = in_valid && in_ready;
        full      = (cnt == CW'(DEPTH));
        first     = (cnt == '0);
        mem_we    = acc && !full;
        mem_waddr = cnt[AW-1:0];
        mem_wdata = in_data;
        commit    = acc && in_last;
        new_cnt   = full ? cnt : cnt + CW'(1);
        cur_lid   = first ? in_lid : w_lid;
        cur_sop   = first ? in_sop : w_sop;
        cur_ap    = (!first && w_ap) || in_aperr;
        cur_dp    = (!first && w_dp) || in_dperr;
        cur_pk    = (!first && w_pk) || in_pkterr || full;
    end

    // Track the byte count and working header, and commit the header on the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            w_lid <= '0;
            w_sop <= 1'b0;
            w_ap  <= 1'b0;
            w_dp  <= 1'b0;
            w_pk  <= 1'b0;
            hdr   <= '0;
        end else if (acc) begin
            if (in_last) begin
                cnt        <= '0;
                hdr.lid    <= 8'(cur_lid);
                hdr.flags  <= {3'b000, cur_pk, cur_dp, cur_ap, in_eop, cur_sop};
                hdr.len_m1 <= 8'(new_cnt - CW'(1));
            end else begin
                cnt   <= new_cnt;
                w_lid <= cur_lid;
                w_sop <= cur_sop;
                w_ap  <= cur_ap;
                w_dp  <= cur_dp;
                w_pk  <= cur_pk;
            end
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8
    trunc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_last && full) |=> hdr.flags[FLAG_PKTERR]);

    // R5
    err_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_last && in_dperr) |=> hdr.flags[FLAG_DPERR]);
endmodule

// File: rtl/frag_cap_store.sv
// Byte storage for one fragment. It has one write port and one synchronous read
// port with a single cycle of latency. It has no reset: the host side masks
// every location beyond the stored length.
module frag_cap_store #(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [7:0]               rdata
);
    logic [7:0] mem [DEPTH];

    // Store an accepted ingress byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch a byte for a host read.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/frag_cap_host.sv
// Host side of the mailbox. It owns the data-available flag, the capture
// event and write-side readiness. It decodes host addresses:
// 0 identifier, 1 flags, 2 length minus one, 3.. data, top address control.
// Read data is returned one cycle after the strobe.
// Assumes commit can only arrive while the flag is clear.
module frag_cap_host
    import frag_cap_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int HAW   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  frag_hdr_t                hdr,
    input  logic                     host_rd,
    input  logic                     host_wr,
    input  logic [HAW-1:0]           host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    output logic                     avail,
    output logic                     cap_event,
    output logic                     in_ready,
    output logic                     mem_re,
    output logic [$clog2(DEPTH)-1:0] mem_raddr,
    input  logic [7:0]               mem_rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [HAW-1:0] CTRL_ADDR = '1;
    localparam logic [HAW-1:0] DATA_LO   = HAW'(HDR_WORDS);
    localparam logic [HAW-1:0] DATA_HI   = HAW'(HDR_WORDS + DEPTH);

    logic [HAW-1:0] idx;
    logic           is_data, in_len, clr;
    rd_sel_t        sel_q;
    logic [7:0]     reg_q;

    // Address decode, including the mask for bytes beyond the stored length.
    always_comb begin
        idx       = host_addr - DATA_LO;
        is_data   = (host_addr >= DATA_LO) && (host_addr < DATA_HI);
        in_len    = (idx <= HAW'(hdr.len_m1));
        mem_re    = host_rd && is_data && in_len;
        mem_raddr = idx[AW-1:0];
        clr       = host_wr && (host_addr == CTRL_ADDR) && !host_wdata[0];
        in_ready  = !avail;
    end

    // Ownership flag and one-cycle capture event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail     <= 1'b0;
            cap_event <= 1'b0;
        end else begin
            cap_event <= commit;
            if (commit)   avail <= 1'b1;
            else if (clr) avail <= 1'b0;
        end
    end

    // Register the source of each host read for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_ZERO;
            reg_q <= '0;
        end else if (host_rd) begin
            reg_q <= '0;
            if (mem_re)                       sel_q <= SEL_MEM;
            else if (host_addr == HAW'(0))  begin sel_q <= SEL_REG; reg_q <= hdr.lid;    end
            else if (host_addr == HAW'(1))  begin sel_q <= SEL_REG; reg_q <= hdr.flags;  end
            else if (host_addr == HAW'(2))  begin sel_q <= SEL_REG; reg_q <= hdr.len_m1; end
            else if (host_addr == CTRL_ADDR) begin sel_q <= SEL_REG; reg_q <= {7'd0, avail}; end
            else                              sel_q <= SEL_ZERO;
        end
    end

    // Choose the read result.
    always_comb begin
        case (sel_q)
            SEL_MEM: host_rdata = mem_rdata;
            SEL_REG: host_rdata = reg_q;
            default: host_rdata = '0;
        endcase
    end

    // R3
    ev_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |=> !cap_event);

    // R3
    ev_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> (avail && !in_ready));

    // R10
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail) |-> $past(host_wr && host_addr == CTRL_ADDR && !host_wdata[0]));

    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !avail && !commit) |=> (!avail && !cap_event));
endmodule

// File: rtl/frag_capture_mbox.sv
// Top of the fragment capture mailbox. It joins the write side, the byte
// storage and the host side. One fragment is held at a time, with an ownership
// handshake: the host owns the buffer while data_avail is high.
module frag_capture_mbox
    import frag_cap_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LID_W = 6,
    parameter int HAW   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [LID_W-1:0] in_lid,
    input  logic             in_aperr,
    input  logic             in_dperr,
    input  logic             in_pkterr,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [HAW-1:0]   host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             data_avail,
    output logic             cap_event
);
    localparam int AW = $clog2(DEPTH);

    logic          mem_we, mem_re, commit;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [7:0]    mem_wdata, mem_rdata;
    frag_hdr_t     hdr;

    frag_cap_writer #(.DEPTH(DEPTH), .LID_W(LID_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_sop(in_sop), .in_eop(in_eop),
        .in_lid(in_lid), .in_aperr(in_aperr), .in_dperr(in_dperr),
        .in_pkterr(in_pkterr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .commit(commit), .hdr(hdr)
    );

    frag_cap_store #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
    );

    frag_cap_host #(.DEPTH(DEPTH), .HAW(HAW)) u_host (
        .clk(clk), .rst_n(rst_n), .commit(commit), .hdr(hdr),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .avail(data_avail),
        .cap_event(cap_event), .in_ready(in_ready), .mem_re(mem_re),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    // R7
    no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !data_avail);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!data_avail && !cap_event));
endmodule

// File: tb/sim_frag_capture_mbox.sv
// Directed bench for the fragment capture mailbox. Each task runs one scenario
// and checks its own results. Inputs change and outputs are sampled at the falling edge.
module sim_frag_capture_mbox;
    localparam int CLK_PERIOD = 10;
    localparam int LID_W = 6;
    localparam int HAW   = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_last = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]       in_data = '0;
    logic [LID_W-1:0] in_lid = '0;
    logic             in_aperr = 1'b0, in_dperr = 1'b0, in_pkterr = 1'b0;
    logic             host_rd = 1'b0, host_wr = 1'b0;
    logic [HAW-1:0]   host_addr = '0;
    logic [7:0]       host_wdata = '0;
    logic [7:0]       host_rdata;
    logic             in_ready, data_avail, cap_event;
    int               n_run = 0, n_fail = 0;
    bit               done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frag_capture_mbox #(.DEPTH(256), .LID_W(LID_W), .HAW(HAW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_sop(in_sop), .in_eop(in_eop),
        .in_lid(in_lid), .in_aperr(in_aperr), .in_dperr(in_dperr),
        .in_pkterr(in_pkterr), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .data_avail(data_avail), .cap_event(cap_event)
    );

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(int'(seed) + i * 3 + (i / 256) * 85);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send n bytes; dp_at / ap_at mark one byte with an error (-1 for none).
    // Returns after the falling edge that follows the final byte.
    task automatic send(input int n, input logic [7:0] seed, input logic [LID_W-1:0] lid,
                        input logic sop, input logic eop, input int ap_at, input int dp_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = pat(seed, i);
            in_last   = (i == n - 1);
            in_sop    = (i == 0) ? sop : 1'b0;
            in_eop    = (i == n - 1) ? eop : 1'b0;
            in_lid    = (i == 0) ? lid : ~lid;
            in_aperr  = (i == ap_at);
            in_dperr  = (i == dp_at);
            in_pkterr = 1'b0;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_aperr = 1'b0; in_dperr = 1'b0;
    endtask

    task automatic rd(input int addr, output int val);
        @(negedge clk);
        host_rd = 1'b1; host_addr = HAW'(addr);
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
        val = int'(host_rdata);
    endtask

    task automatic wr(input int addr, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = HAW'(addr); host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 avail", int'(data_avail), 0);
        chk("R1 event", int'(cap_event), 0);
        chk("R1 ready", int'(in_ready), 1);
    endtask

    task automatic t_short;
        int v;
        send(5, 8'h10, 6'd5, 1'b1, 1'b1, -1, 2);
        chk("R3 avail set", int'(data_avail), 1);
        chk("R3 event pulse", int'(cap_event), 1);
        @(negedge clk);
        chk("R3 event one cycle", int'(cap_event), 0);
        rd(0, v);   chk("R6 lid", v, 5);
        rd(1, v);   chk("R5 flags sop eop dperr", v, 8'h0B);
        rd(2, v);   chk("R4 length 5", v, 4);
        for (int i = 0; i < 5; i++) begin
            rd(3 + i, v); chk("R2 data", v, int'(pat(8'h10, i)));
        end
        rd(8, v);   chk("R9 beyond length", v, 0);
        rd(300, v); chk("R9 gap address", v, 0);
        rd(511, v); chk("R10 ctrl read", v, 1);
    endtask

    task automatic t_busy;
        int v;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 ready low", int'(in_ready), 0);
            in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1; in_sop = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_sop = 1'b0;
        chk("R7 no event", int'(cap_event), 0);
        rd(3, v); chk("R7 data kept", v, int'(pat(8'h10, 0)));
        rd(2, v); chk("R7 length kept", v, 4);
        rd(1, v); chk("R7 flags kept", v, 8'h0B);
    endtask

    task automatic t_clear;
        wr(511, 8'h01);
        chk("R10 set write ignored", int'(data_avail), 1);
        wr(511, 8'h00);
        chk("R10 clear", int'(data_avail), 0);
        chk("R10 ready back", int'(in_ready), 1);
        wr(511, 8'h00);
        chk("R11 stays clear", int'(data_avail), 0);
        chk("R11 no event", int'(cap_event), 0);
        @(negedge clk);
        chk("R11 no event later", int'(cap_event), 0);
    endtask

    task automatic t_full;
        int v;
        send(256, 8'h40, 6'h2A, 1'b1, 1'b0, -1, -1);
        chk("R3 full avail", int'(data_avail), 1);
        rd(2, v);   chk("R4 length 256", v, 255);
        rd(1, v);   chk("R5 flags sop only", v, 8'h01);
        rd(0, v);   chk("R6 lid 2A", v, 8'h2A);
        rd(3, v);   chk("R2 first byte", v, int'(pat(8'h40, 0)));
        rd(258, v); chk("R2 last byte", v, int'(pat(8'h40, 255)));
        wr(511, 8'h00);
    endtask

    task automatic t_short_after_full;
        int v;
        send(3, 8'h80, 6'd9, 1'b0, 1'b0, -1, -1);
        rd(1, v); chk("R5 flags none", v, 0);
        rd(5, v); chk("R2 short last", v, int'(pat(8'h80, 2)));
        rd(6, v); chk("R9 stale masked", v, 0);
        rd(258, v); chk("R9 stale top masked", v, 0);
        wr(511, 8'h00);
    endtask

    task automatic t_trunc;
        int v;
        send(260, 8'h22, 6'd3, 1'b0, 1'b1, 0, -1);
        chk("R8 avail after trunc", int'(data_avail), 1);
        rd(2, v);   chk("R8 length capped", v, 255);
        rd(1, v);   chk("R8 flags eop aperr pkterr", v, 8'h16);
        rd(3, v);   chk("R8 first byte intact", v, int'(pat(8'h22, 0)));
        rd(258, v); chk("R8 byte 255 kept", v, int'(pat(8'h22, 255)));
        wr(511, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short();
        t_busy();
        t_clear();
        t_full();
        t_short_after_full();
        t_trunc();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule